// File: doc/BRIEF.md
# Tagged Add/Subtract Unit

This unit executes tagged integer arithmetic. The two least significant bits of each operand hold a type tag, and an operand whose tag is not zero is treated as a non-integer value. There are four operations: add, subtract, and a trapping form of each. The unit returns the sum or difference, a destination write enable, a set of flags for the low 32-bit word and a set of extended flags for the full 64-bit word. In the trapping forms it can instead raise a trap request that carries a trap-type code.

A width-mode input selects between 32-bit operation and 64-bit operation. In 32-bit mode only the low word exists: the extended flags and the upper half of the result are zero. In 64-bit mode both flag sets are produced. All outputs are registered and appear one clock after the input valid strobe. Operand fetch, instruction decode and trap handling belong to the surrounding pipeline.

Top module: `tag_alu`

## Requirements
- R1: `valid_o` is high exactly one clock after a cycle with `valid_i` high. The operation select `op_i` encodes 0 = tagged add, 1 = tagged subtract, 2 = tagged add with trap, 3 = tagged subtract with trap.
- R2: On a completed operation, `result_o` is a+b or a-b modulo 2^64, and `wr_en_o` pulses with `valid_o`. With `mode32_i` high the operands are cut to their low 32 bits and bits [63:32] of `result_o` are zero.
- R3: Flag vectors are {N,Z,V,C} at bits {3,2,1,0}. In `icc_o`, N and Z come from bits [31:0] of the result. In `xcc_o`, N and Z come from all 64 bits.
- R4: For add, C is set when the result is below the first operand, compared unsigned. For subtract, C is set when the first operand is below the second, compared unsigned. `icc_o` C uses only the low 32 bits; `xcc_o` C uses all 64 bits.
- R5: In the non-trapping forms, `icc_o` V is set when 32-bit signed overflow occurs or when either operand has a nonzero tag in bits [1:0]. `xcc_o` V is the 64-bit signed overflow and does not depend on the tags.
- R6: A trapping form raises `trap_o` for one cycle, in place of the write, when either tag is nonzero or 32-bit signed overflow occurs. `trap_code_o` is 0x0A in 32-bit mode and 0x23 in 64-bit mode, and is 0 whenever `trap_o` is low. `wr_en_o` stays low on a trap.
- R7: On a trap, `result_o`, `icc_o` and `xcc_o` keep their previous values.
- R8: A trapping form that does not trap writes both V flags as zero, and its other flags follow the rules of R3 and R4.
- R9: With `mode32_i` high, `xcc_o` is written as zero.
- R10: While `rst_ni` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| mode32_i | input | 1 | 1 = 32-bit mode, 0 = 64-bit mode |
| op_i | input | 2 | Operation select |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| valid_o | output | 1 | Result cycle |
| result_o | output | 64 | Result |
| wr_en_o | output | 1 | Destination write enable |
| icc_o | output | 4 | 32-bit flags {N,Z,V,C} |
| xcc_o | output | 4 | 64-bit flags {N,Z,V,C} |
| trap_o | output | 1 | Tag-overflow trap request |
| trap_code_o | output | 8 | Trap-type code |

## Verification
A tag fault and a 32-bit signed overflow can occur in the same operation. In the non-trapping forms both of them drive the same V flag; in the trapping forms both of them feed the same single trap. The directed case 0x7FFFFFFF plus 1 provokes this, because it overflows and also carries a tag of 3. Cases with an overflow but clean tags (0x7FFFFFFC plus 4) and with a tag fault alone show that each cause works without the other. Each result is judged against a bench model that sets the flags, the trap and the held values, independently of the RTL.

// File: rtl/tag_alu_pkg.sv
package tag_alu_pkg;
  typedef enum logic [1:0] {
    OP_TADD    = 2'd0,
    OP_TSUB    = 2'd1,
    OP_TADD_TV = 2'd2,
    OP_TSUB_TV = 2'd3
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/tag_alu_lane.sv
module tag_alu_lane
  import tag_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] res_i,
  input  logic         sub_i,
  output flags_t       flags_o
);
  logic same_sign;
  logic res_flip;

  assign same_sign = ~(a_i[W-1] ^ b_i[W-1]);
  assign res_flip  = a_i[W-1] ^ res_i[W-1];

  always_comb begin
    flags_o.n = res_i[W-1];
    flags_o.z = (res_i == '0);
    // the carry of a subtract is a borrow
    flags_o.c = sub_i ? (a_i < b_i) : (res_i < a_i);
    flags_o.v = res_flip & (sub_i ? ~same_sign : same_sign);
  end
endmodule

// File: rtl/tag_alu_core.sv
module tag_alu_core
  import tag_alu_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned HLEN  = 32,
  parameter int unsigned TAG_W = 2
) (
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  input  logic [1:0]      op_i,
  input  logic            mode32_i,
  output logic [XLEN-1:0] res_o,
  output flags_t          icc_o,
  output flags_t          xcc_o,
  output logic            trap_o
);
  localparam int unsigned UPW = XLEN - HLEN;

  logic [XLEN-1:0] a_m, b_m, sum;
  logic            is_sub, trap_form, tag_err;
  flags_t          lo_f, hi_f;

  assign is_sub    = op_i[0];
  assign trap_form = op_i[1];

  assign a_m = mode32_i ? {{UPW{1'b0}}, opa_i[HLEN-1:0]} : opa_i;
  assign b_m = mode32_i ? {{UPW{1'b0}}, opb_i[HLEN-1:0]} : opb_i;
  assign sum = is_sub ? (a_m - b_m) : (a_m + b_m);
  assign res_o = mode32_i ? {{UPW{1'b0}}, sum[HLEN-1:0]} : sum;

  assign tag_err = (|a_m[TAG_W-1:0]) | (|b_m[TAG_W-1:0]);

  tag_alu_lane #(.W(HLEN)) u_lo (
    .a_i    (a_m[HLEN-1:0]),
    .b_i    (b_m[HLEN-1:0]),
    .res_i  (sum[HLEN-1:0]),
    .sub_i  (is_sub),
    .flags_o(lo_f)
  );

  tag_alu_lane #(.W(XLEN)) u_hi (
    .a_i    (a_m),
    .b_i    (b_m),
    .res_i  (sum),
    .sub_i  (is_sub),
    .flags_o(hi_f)
  );

  assign trap_o = trap_form & (tag_err | lo_f.v);

  always_comb begin
    icc_o   = lo_f;
    icc_o.v = trap_form ? 1'b0 : (lo_f.v | tag_err);
    xcc_o   = hi_f;
    xcc_o.v = trap_form ? 1'b0 : hi_f.v;
    if (mode32_i) xcc_o = '0;
  end
endmodule

// File: rtl/tag_alu.sv
module tag_alu
  import tag_alu_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned HLEN    = 32,
  parameter int unsigned TAG_W   = 2,
  parameter int unsigned CODE_W  = 8,
  parameter logic [7:0]  CODE_32 = 8'h0A,
  parameter logic [7:0]  CODE_64 = 8'h23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              mode32_i,
  input  logic [1:0]        op_i,
  input  logic [XLEN-1:0]   opa_i,
  input  logic [XLEN-1:0]   opb_i,
  output logic              valid_o,
  output logic [XLEN-1:0]   result_o,
  output logic              wr_en_o,
  output logic [3:0]        icc_o,
  output logic [3:0]        xcc_o,
  output logic              trap_o,
  output logic [CODE_W-1:0] trap_code_o
);
  logic [XLEN-1:0] res_d;
  flags_t          icc_d, xcc_d;
  logic            trap_d;

  tag_alu_core #(.XLEN(XLEN), .HLEN(HLEN), .TAG_W(TAG_W)) u_core (
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .op_i    (op_i),
    .mode32_i(mode32_i),
    .res_o   (res_d),
    .icc_o   (icc_d),
    .xcc_o   (xcc_d),
    .trap_o  (trap_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      result_o    <= '0;
      wr_en_o     <= 1'b0;
      icc_o       <= '0;
      xcc_o       <= '0;
      trap_o      <= 1'b0;
      trap_code_o <= '0;
    end else begin
      valid_o     <= valid_i;
      wr_en_o     <= valid_i & ~trap_d;
      trap_o      <= valid_i & trap_d;
      trap_code_o <= '0;
      if (valid_i && trap_d) begin
        trap_code_o <= mode32_i ? CODE_W'(CODE_32) : CODE_W'(CODE_64);
      end else if (valid_i) begin
        // a trap leaves the architectural state untouched
        result_o <= res_d;
        icc_o    <= icc_d;
        xcc_o    <= xcc_d;
      end
    end
  end
endmodule

// File: rtl/tag_alu_chk.sv
module tag_alu_chk #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned CODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              mode32_i,
  input logic [1:0]        op_i,
  input logic              valid_o,
  input logic [XLEN-1:0]   result_o,
  input logic              wr_en_o,
  input logic [3:0]        icc_o,
  input logic [3:0]        xcc_o,
  input logic              trap_o,
  input logic [CODE_W-1:0] trap_code_o
);
  assert_valid_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  assert_write_or_trap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_en_o, trap_o}) && ((wr_en_o || trap_o) == valid_o));

  assert_trap_only_tv_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(op_i[1]));

  assert_trap_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (trap_code_o == ($past(mode32_i) ? CODE_W'(8'h0A) : CODE_W'(8'h23))));

  assert_code_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> (trap_code_o == '0));

  assert_trap_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> ($stable(result_o) && $stable(icc_o) && $stable(xcc_o)));

  assert_tv_no_ovf_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(op_i[1])) |-> (!icc_o[1] && !xcc_o[1]));

  assert_mode32_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(mode32_i)) |-> (xcc_o == 4'd0 && result_o[XLEN-1:32] == '0));
endmodule

bind tag_alu tag_alu_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/tb_tag_alu.sv
module tb_tag_alu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        mode32_i = 1'b0;
  logic [1:0]  op_i = 2'd0;
  logic [63:0] opa_i = '0, opb_i = '0;
  logic        valid_o, wr_en_o, trap_o;
  logic [63:0] result_o;
  logic [3:0]  icc_o, xcc_o;
  logic [7:0]  trap_code_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [63:0] e_res = '0;
  logic [3:0]  e_icc = '0, e_xcc = '0;

  always #2 clk_i = ~clk_i;

  tag_alu dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] op, input logic [63:0] a_in, input logic [63:0] b_in,
                     input logic m32);
    logic [63:0] a, b, r;
    logic sub, trp, tag, o32, o64, c32, c64, trap;
    a = m32 ? {32'd0, a_in[31:0]} : a_in;
    b = m32 ? {32'd0, b_in[31:0]} : b_in;
    sub = op[0];
    trp = op[1];
    r = sub ? a - b : a + b;
    if (m32) r[63:32] = '0;
    tag = (a[1:0] != 0) || (b[1:0] != 0);
    o32 = (r[31] != a[31]) && (sub ? (a[31] != b[31]) : (a[31] == b[31]));
    o64 = (r[63] != a[63]) && (sub ? (a[63] != b[63]) : (a[63] == b[63]));
    c32 = sub ? (a[31:0] < b[31:0]) : (r[31:0] < a[31:0]);
    c64 = sub ? (a < b) : (r < a);
    trap = trp && (tag || o32);
    opa_i = a_in; opb_i = b_in; op_i = op; mode32_i = m32; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R1 valid", {63'd0, valid_o}, 64'd1);
    chk("R6 trap", {63'd0, trap_o}, {63'd0, trap});
    chk("R6 code", {56'd0, trap_code_o}, trap ? (m32 ? 64'h0A : 64'h23) : 64'h0);
    chk("R2 wr_en", {63'd0, wr_en_o}, {63'd0, !trap});
    if (trap) begin
      chk("R7 hold result", result_o, e_res);
      chk("R7 hold icc", {60'd0, icc_o}, {60'd0, e_icc});
      chk("R7 hold xcc", {60'd0, xcc_o}, {60'd0, e_xcc});
    end else begin
      e_res = r;
      e_icc = {r[31], r[31:0] == 0, trp ? 1'b0 : (o32 || tag), c32};
      e_xcc = m32 ? 4'd0 : {r[63], r == 0, trp ? 1'b0 : o64, c64};
      chk("R2 result", result_o, e_res);
      chk("R3 icc NZ", {62'd0, icc_o[3:2]}, {62'd0, e_icc[3:2]});
      chk("R4 icc C", {63'd0, icc_o[0]}, {63'd0, e_icc[0]});
      chk(trp ? "R8 icc V" : "R5 icc V", {63'd0, icc_o[1]}, {63'd0, e_icc[1]});
      if (m32) chk("R9 xcc zero", {60'd0, xcc_o}, 64'd0);
      else begin
        chk("R3 xcc NZ", {62'd0, xcc_o[3:2]}, {62'd0, e_xcc[3:2]});
        chk("R4 xcc C", {63'd0, xcc_o[0]}, {63'd0, e_xcc[0]});
        chk(trp ? "R8 xcc V" : "R5 xcc V", {63'd0, xcc_o[1]}, {63'd0, e_xcc[1]});
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    #1;
    chk("R10 reset out", {valid_o, wr_en_o, trap_o, icc_o, xcc_o, trap_code_o, 45'd0}, 64'd0);
    chk("R10 reset result", result_o, 64'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle", {62'd0, valid_o, wr_en_o}, 64'd0);
    for (int op = 0; op < 4; op++) begin
      for (int m = 0; m < 2; m++) begin
        for (int t = 0; t < 16; t++)
          run(2'(op), 64'h100 | 64'(t[1:0]), 64'h200 | 64'(t[3:2]), m[0]);
        run(2'(op), 64'h7FFF_FFFF, 64'h1, m[0]);
        run(2'(op), 64'h7FFF_FFFC, 64'h4, m[0]);
        run(2'(op), 64'h8000_0000, 64'h1, m[0]);
        run(2'(op), 64'h8000_0000, 64'h4, m[0]);
        run(2'(op), 64'hFFFF_FFFF_FFFF_FFFC, 64'h4, m[0]);
        run(2'(op), 64'h7FFF_FFFF_FFFF_FFFC, 64'h4, m[0]);
        run(2'(op), 64'h8000_0000_0000_0000, 64'h4, m[0]);
        run(2'(op), 64'h4, 64'h4, m[0]);
      end
    end
    for (int i = 0; i < 2000; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if ($urandom_range(3) != 0) a[1:0] = 2'b00;
      if ($urandom_range(3) != 0) b[1:0] = 2'b00;
      run(2'($urandom_range(3)), a, b, 1'($urandom_range(1)));
      if ($urandom_range(7) == 0) begin
        @(negedge clk_i);
        chk("R1 bubble", {62'd0, valid_o, wr_en_o}, 64'd0);
      end
    end
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule